// File: doc/BRIEF.md
# Half-Pixel Motion Compensation Interpolator

This block builds one 8x8 predicted pixel block from a reference region. The region arrives as a stream of rows, one row per accepted beat, and the block returns the predicted rows as a second stream. A motion vector with half-pixel precision sets two flags, one horizontal and one vertical. Together they pick one of four operations: a plain copy, an average of vertically adjacent pixels, an average of horizontally adjacent pixels, or a rounded four-pixel bilinear average.

Each input beat carries nine 8-bit pixels. The ninth pixel is read only when the horizontal flag is set. When the vertical flag is set the block takes nine rows in and produces eight rows out. The first of those nine rows only primes a line register that holds the previous row. The two-pixel average is computed on the whole 64-bit output word at once, at 8-bit lane width, with no wider intermediate. The four-pixel mode uses a 10-bit sum per lane. Both handshakes use valid/ready, and a new block may follow the previous one with no idle cycle.

Top module: `halfpel_interp`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: With both flags 0 (copy), a block takes 8 input rows. Output row k, lane i (bits 8i+7:8i), equals input pixel i of row k. Input pixel j sits at in_pix bits 8j+7:8j, for j from 0 to 8.
- R3: With the horizontal flag 1 and the vertical flag 0, a block takes 8 rows. Output row k, lane i, is (p[k][i]+p[k][i+1]+1)>>1, where p[k][j] is pixel j of input row k.
- R4: With the vertical flag 1 and the horizontal flag 0, a block takes 9 rows, and the first row produces no output. Output row k, lane i, is (p[k][i]+p[k+1][i]+1)>>1.
- R5: With both flags 1, a block takes 9 rows, and the first row produces no output. Output row k, lane i, is (p[k][i]+p[k][i+1]+p[k+1][i]+p[k+1][i+1]+2)>>2. This holds for every value, including all pixels at 255.
- R6: in_hx and in_hy are sampled only on the first row of a block. Their values on the block's later rows have no effect on the output.
- R7: out_last is high on the eighth output row of each block and low on the other rows.
- R8: While out_valid is high and out_ready is low, out_pix, out_last and out_valid hold their values and in_ready is low.
- R9: When out_ready is held high, in_ready stays high. Every row is accepted on consecutive cycles, including across back-to-back blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input row valid |
| in_ready | output | 1 | Input row can be accepted |
| in_hx | input | 1 | Horizontal half-pixel flag, read on the first row of a block |
| in_hy | input | 1 | Vertical half-pixel flag, read on the first row of a block |
| in_pix | input | 72 | Nine reference pixels, pixel j at bits 8j+7:8j |
| out_valid | output | 1 | Predicted row valid |
| out_ready | input | 1 | Downstream accepts the predicted row |
| out_pix | output | 64 | Eight predicted pixels, lane i at bits 8i+7:8i |
| out_last | output | 1 | Last row of the predicted block |

## Verification
A row accepted at a clock edge shows up on out_pix right after that same edge, with one register stage between them. When the vertical flag is set, the block's first accepted row never produces an output. The bench drives inputs on the falling edge and tests in_ready just after it, so a row counts as accepted only at the next rising edge. It samples the outputs two time steps after each falling edge and pairs each transfer with the next entry in a list of expected rows, so the checks do not depend on how long a stall lasts. Whenever out_ready was held low, the next sample compares the output against the value recorded before the stall.

// File: rtl/halfpel_interp.sv
module halfpel_interp #(
  parameter int PIXW  = 8,
  parameter int LANES = 8,
  parameter int ROWS  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_hx,
  input  logic                        in_hy,
  input  logic [(LANES+1)*PIXW-1:0]   in_pix,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [LANES*PIXW-1:0]       out_pix,
  output logic                        out_last
);
  localparam int OW = LANES * PIXW;
  localparam int IW = OW + PIXW;
  localparam int CW = $clog2(ROWS + 1);
  localparam int SW = PIXW + 2;

  function automatic logic [OW-1:0] lane_lsb();
    logic [OW-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) m[i*PIXW] = 1'b1;
    return m;
  endfunction
  localparam logic [OW-1:0] LSB = lane_lsb();

  function automatic logic [OW-1:0] avg2(input logic [OW-1:0] x, input logic [OW-1:0] y);
    return ((x & ~LSB) >> 1) + ((y & ~LSB) >> 1) + ((x | y) & LSB);
  endfunction

  logic [CW-1:0] rcnt;
  logic          hx_q, hy_q;
  logic [IW-1:0] line_q;

  logic first, hx_e, hy_e, fire, emit;
  logic [CW-1:0] last_idx;
  logic [OW-1:0] cur_a, cur_b, prv_a, prv_b, quad, result;

  assign first    = (rcnt == '0);
  assign hx_e     = first ? in_hx : hx_q;
  assign hy_e     = first ? in_hy : hy_q;
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign emit     = !(hy_e && first);
  assign last_idx = hy_e ? CW'(ROWS) : CW'(ROWS - 1);

  assign cur_a = in_pix[OW-1:0];
  assign cur_b = in_pix[IW-1:PIXW];
  assign prv_a = line_q[OW-1:0];
  assign prv_b = line_q[IW-1:PIXW];

  for (genvar l = 0; l < LANES; l++) begin : g_quad
    logic [SW-1:0] sum;
    assign sum = SW'(cur_a[l*PIXW +: PIXW]) + SW'(cur_b[l*PIXW +: PIXW])
               + SW'(prv_a[l*PIXW +: PIXW]) + SW'(prv_b[l*PIXW +: PIXW]) + SW'(2);
    assign quad[l*PIXW +: PIXW] = sum[SW-1:2];
  end

  always_comb begin
    case ({hy_e, hx_e})
      2'b00:   result = cur_a;
      2'b01:   result = avg2(cur_a, cur_b);
      2'b10:   result = avg2(prv_a, cur_a);
      default: result = quad;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt      <= '0;
      hx_q      <= 1'b0;
      hy_q      <= 1'b0;
      line_q    <= '0;
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_last  <= 1'b0;
    end else begin
      if (fire) begin
        line_q <= in_pix;
        if (first) begin
          hx_q <= in_hx;
          hy_q <= in_hy;
        end
        rcnt <= (rcnt == last_idx) ? '0 : rcnt + CW'(1);
      end
      if (fire && emit) begin
        out_valid <= 1'b1;
        out_pix   <= result;
        out_last  <= (rcnt == last_idx);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

module halfpel_interp_chk #(
  parameter int PIXW  = 8,
  parameter int LANES = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      fire,
  input logic                      first,
  input logic                      hx_e,
  input logic                      hy_e,
  input logic [(LANES+1)*PIXW-1:0] in_pix,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [LANES*PIXW-1:0]     out_pix,
  input logic                      out_last
);
  localparam int OW = LANES * PIXW;
  logic [PIXW-1:0] q_a, q_b;
  logic [PIXW:0]   h_sum;
  logic            seen_rst;

  always_ff @(posedge clk) begin
    q_a <= in_pix[PIXW-1:0];
    q_b <= in_pix[2*PIXW-1:PIXW];
    seen_rst <= !rst_n ? 1'b1 : seen_rst;
  end
  assign h_sum = ({1'b0, q_a} + {1'b0, q_b} + 1'b1);

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_rst && !$past(rst_n)) |-> (!out_valid && in_ready));

  a_r2_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hx_e && !hy_e) |=> (out_valid && out_pix == $past(in_pix[OW-1:0])));

  a_r3_hlane0: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hx_e && !hy_e) |=> (out_pix[PIXW-1:0] == h_sum[PIXW:1]));

  a_r4_prime_row: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && first && hy_e) |=> !out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_last)));

  a_r8_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind halfpel_interp halfpel_interp_chk #(.PIXW(PIXW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .fire(fire), .first(first), .hx_e(hx_e), .hy_e(hy_e),
  .in_pix(in_pix), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_pix(out_pix), .out_last(out_last)
);

// File: tb/test_halfpel_interp.sv
module test_halfpel_interp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_hx = 1'b0, in_hy = 1'b0, out_ready = 1'b1;
  logic [71:0] in_pix = '0;
  logic in_ready, out_valid, out_last;
  logic [63:0] out_pix;

  always #4 clk = ~clk;

  halfpel_interp i_halfpel_interp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hx(in_hx), .in_hy(in_hy), .in_pix(in_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix), .out_last(out_last)
  );

  int total = 0, bad = 0;
  int blk [0:8][0:8];
  logic [63:0] exp_pix [0:1023];
  bit          exp_last [0:1023];
  int          exp_mode [0:1023];
  int wr = 0, rd = 0;
  int stall_mode = 0;
  int waits = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R2 copy";
      1: return "R3 horizontal";
      2: return "R4 vertical";
      default: return "R5 bilinear";
    endcase
  endfunction

  task automatic fill(input int pat);
    for (int r = 0; r < 9; r++)
      for (int j = 0; j < 9; j++)
        case (pat)
          0: blk[r][j] = int'($urandom % 256);
          1: blk[r][j] = 255;
          2: blk[r][j] = 0;
          3: blk[r][j] = ((r + j) % 2) ? 255 : 0;
          4: blk[r][j] = ((r * 3 + j) % 2) ? 254 : 255;
          default: blk[r][j] = 240 + int'($urandom % 16);
        endcase
  endtask

  task automatic push_expected(input bit hx, input bit hy);
    for (int k = 0; k < 8; k++) begin
      logic [63:0] row;
      for (int i = 0; i < 8; i++) begin
        int v;
        case ({hy, hx})
          2'b00: v = blk[k][i];
          2'b01: v = (blk[k][i] + blk[k][i+1] + 1) / 2;
          2'b10: v = (blk[k][i] + blk[k+1][i] + 1) / 2;
          default: v = (blk[k][i] + blk[k][i+1] + blk[k+1][i] + blk[k+1][i+1] + 2) / 4;
        endcase
        row[i*8 +: 8] = 8'(v);
      end
      exp_pix[wr]  = row;
      exp_last[wr] = (k == 7);
      exp_mode[wr] = {30'd0, hy, hx};
      wr++;
    end
  endtask

  // R6: later rows carry inverted flags, which must be ignored
  task automatic send_block(input bit hx, input bit hy);
    int nrows;
    nrows = hy ? 9 : 8;
    push_expected(hx, hy);
    for (int r = 0; r < nrows; r++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_hx = (r == 0) ? hx : ~hx;
      in_hy = (r == 0) ? hy : ~hy;
      for (int j = 0; j < 9; j++) in_pix[j*8 +: 8] = 8'(blk[r][j]);
      #1;
      while (!in_ready) begin
        waits++;
        @(negedge clk);
        #1;
      end
    end
  endtask

  task automatic idle_input();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : collector
    bit hold_chk;
    logic [63:0] hp;
    logic hl;
    hold_chk = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = (stall_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      #2;
      if (rst_n) begin
        if (hold_chk)
          check(out_valid && out_pix == hp && out_last == hl, "R8 hold", out_pix, hp);
        hold_chk = 1'b0;
        if (out_valid && !out_ready) begin
          check(!in_ready, "R8 in_ready low", {63'd0, in_ready}, 64'd0);
          hold_chk = 1'b1;
          hp = out_pix;
          hl = out_last;
        end
        if (out_valid && out_ready) begin
          if (rd >= wr) begin
            check(1'b0, "R4 unexpected row", out_pix, 64'd0);
          end else begin
            check(out_pix == exp_pix[rd], {mode_tag(exp_mode[rd]), " R6"}, out_pix, exp_pix[rd]);
            check(out_last == exp_last[rd], "R7 last", {63'd0, out_last}, {63'd0, exp_last[rd]});
            rd++;
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    #2;
    check(!out_valid && in_ready, "R1 reset", {62'd0, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(!out_valid && in_ready, "R1 after reset", {62'd0, out_valid, in_ready}, 64'd1);

    // R9: back-to-back blocks with no stalls
    stall_mode = 0;
    waits = 0;
    fill(0); send_block(1'b0, 1'b1);
    fill(0); send_block(1'b1, 1'b1);
    fill(0); send_block(1'b0, 1'b0);
    idle_input();
    check(waits == 0, "R9 no wait", 64'(waits), 64'd0);

    for (int rep = 0; rep < 3; rep++)
      for (int pat = 0; pat < 6; pat++)
        for (int m = 0; m < 4; m++) begin
          stall_mode = (rep + m) % 2;
          fill(pat);
          send_block(m[0], m[1]);
        end
    idle_input();
    stall_mode = 0;
    while (rd < wr) @(negedge clk);
    repeat (3) @(negedge clk);
    #2;
    check(!out_valid, "R7 drained", {63'd0, out_valid}, 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule